// File: doc/BRIEF.md
# Bus Trace Capture Buffer

The block is a capture memory for bus-sample bundles. Each bundle is made of three 128-bit bus transactions, split into six 64-bit words. After a reset command the buffer waits for a start trigger. Once the trigger fires, every valid sample is written into a circular store of `DEPTH` bundles.

With the freeze option set, capture stops as soon as the store is full, and a level interrupt is raised. With the option clear, the store wraps and keeps the most recent `DEPTH` bundles.

Software reads the store through one 64-bit port. It first writes a start-read command. It then issues one read strobe per word. The newest bundle comes out first, and inside each bundle the words come out from the last to the first.

Top module: `trace_buf`

## Requirements
- R1: A bundle is the sample input split into six words: word w is `smp_data_i[64*w+63:64*w]`. In order w = 0..5 these are transaction 0 low, transaction 0 high, transaction 1 low, transaction 1 high, transaction 2 low and transaction 2 high. The store holds `DEPTH` bundles (256 by default).
- R2: Samples are captured only after a start trigger has been seen while waiting. A sample presented before the trigger is dropped, and so is a sample presented in the same cycle as the trigger.
- R3: During capture, each valid sample is written at the write pointer. The pointer then advances by one bundle and wraps from `DEPTH-1` to 0.
- R4: While the freeze option is set, the write that makes the store hold `DEPTH` bundles stops capture. `frz_irq_o` is high from the next cycle and stays high until a reset command.
- R5: While the freeze option is clear, a full store wraps: the oldest bundle is overwritten, the last `DEPTH` bundles are kept, and `frz_irq_o` stays low.
- R6: A configuration write with bit 0 set is a reset command. It empties the store, zeroes the write pointer, drops `frz_irq_o` and returns the block to waiting for a trigger. It takes priority over a start-read in the same write.
- R7: A configuration write with bit 1 set is a start-read command. It ends capture and prepares the read port, and a repeated start-read restarts the readout from the newest bundle. Bit 2 of every configuration write sets the freeze option.
- R8: After a start-read, each read strobe returns one word on `rd_data_o` in the following cycle. Bundles come newest first, and each bundle yields words 5, 4, 3, 2, 1, 0, so six reads per held bundle drain the store.
- R9: A read before any start-read, a read after the store is drained, and a read in the cycle of a start-read or reset command all return zero and move no pointer. `rd_data_o` holds its value in cycles without a read.
- R10: Samples that arrive while frozen or during readout are dropped, and the read-out contents do not change.
- R11: A start trigger outside the waiting state has no effect.
- R12: After reset, `frz_irq_o` is low and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 64 | Command word: bit 0 reset, bit 1 start-read, bit 2 freeze option |
| trig_i | input | 1 | Start trigger |
| smp_valid_i | input | 1 | Sample valid |
| smp_data_i | input | 384 | Three 128-bit transactions, transaction 0 in the low bits |
| rd_i | input | 1 | Read strobe, one word per strobe |
| rd_data_o | output | 64 | Read word, valid the cycle after the strobe |
| frz_irq_o | output | 1 | Freeze interrupt, level |

## Verification
The bench builds the block with `DEPTH` set to 8 and keeps the default word width and transaction count. With this depth, filling the store, freezing, wrapping past full and draining the whole store all fit in a few hundred cycles. Every word carries its bundle seed and word index, so any slip in the reversed order, the pointer wrap or the bundle format shows up in a single compare.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CAPT   = 2'd1,
    ST_FROZEN = 2'd2,
    ST_READ   = 2'd3
  } st_e;

  localparam int CMD_RST = 0;
  localparam int CMD_RD  = 1;
  localparam int CMD_FRZ = 2;
endpackage

// File: rtl/trace_store.sv
module trace_store #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 6,
  parameter int DEPTH  = 256,
  parameter int PTR_W  = 8,
  parameter int WIDX_W = 3
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [PTR_W-1:0]          waddr_i,
  input  logic [WORDS*WORD_W-1:0]   wdata_i,
  input  logic [PTR_W-1:0]          raddr_i,
  input  logic [WIDX_W-1:0]         rword_i,
  output logic [WORD_W-1:0]         rdata_o
);
  logic [WORD_W-1:0] bank_q [WORDS];

  // one bank per word slot, so the read mux sits after the bank decode
  for (genvar g = 0; g < WORDS; g++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i[g*WORD_W +: WORD_W];
    end
    assign bank_q[g] = mem[raddr_i];
  end

  assign rdata_o = bank_q[rword_i];
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl import trace_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int PTR_W = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic             cmd_rst_i,
  input  logic             cmd_rd_i,
  input  logic             frz_opt_i,
  input  logic             trig_i,
  input  logic             smp_valid_i,
  output st_e              state_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frz_en_o,
  output logic             irq_o,
  output logic             rd_load_o,
  output logic             clear_o
);
  st_e              state_q;
  logic [PTR_W-1:0] wptr_q, wptr_inc;
  logic [CNT_W-1:0] cnt_q;
  logic             frz_en_q, irq_q, fills, cmd_any;

  assign cmd_any  = cmd_rst_i | cmd_rd_i;
  assign wr_en_o  = (state_q == ST_CAPT) & smp_valid_i & ~cmd_any;
  assign wptr_inc = (wptr_q == PTR_W'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
  assign fills    = cnt_q >= CNT_W'(DEPTH-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wptr_q   <= '0;
      cnt_q    <= '0;
      frz_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (cmd_we_i) frz_en_q <= frz_opt_i;
      if (cmd_rst_i) begin
        state_q <= ST_IDLE;
        wptr_q  <= '0;
        cnt_q   <= '0;
        irq_q   <= 1'b0;
      end else if (cmd_rd_i) begin
        state_q <= ST_READ;
      end else begin
        if (state_q == ST_IDLE && trig_i) state_q <= ST_CAPT;
        if (wr_en_o) begin
          wptr_q <= wptr_inc;
          if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
          if (fills && frz_en_q) begin
            state_q <= ST_FROZEN;
            irq_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign state_o   = state_q;
  assign wptr_o    = wptr_q;
  assign cnt_o     = cnt_q;
  assign frz_en_o  = frz_en_q;
  assign irq_o     = irq_q;
  assign clear_o   = cmd_rst_i;
  assign rd_load_o = cmd_rd_i & ~cmd_rst_i;
endmodule

// File: rtl/trace_rdout.sv
module trace_rdout #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 6,
  parameter int DEPTH  = 256,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 9,
  parameter int WIDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic [CNT_W-1:0]  left_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [PTR_W-1:0]  rptr_q, newest, rptr_dec;
  logic [WIDX_W-1:0] widx_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] rdata_q;

  assign newest   = (wptr_i == '0) ? PTR_W'(DEPTH-1) : wptr_i - 1'b1;
  assign rptr_dec = (rptr_q == '0) ? PTR_W'(DEPTH-1) : rptr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      widx_q  <= WIDX_W'(WORDS-1);
      left_q  <= '0;
      rdata_q <= '0;
    end else if (clear_i) begin
      left_q  <= '0;
      rdata_q <= '0;
    end else if (load_i) begin
      rptr_q <= newest;
      widx_q <= WIDX_W'(WORDS-1);
      left_q <= cnt_i;
      if (rd_i) rdata_q <= '0;
    end else if (rd_i) begin
      if (left_q != '0) begin
        rdata_q <= word_i;
        if (widx_q == '0) begin
          widx_q <= WIDX_W'(WORDS-1);
          left_q <= left_q - 1'b1;
          rptr_q <= rptr_dec;
        end else begin
          widx_q <= widx_q - 1'b1;
        end
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign rptr_o  = rptr_q;
  assign widx_o  = widx_q;
  assign left_o  = left_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/trace_buf.sv
module trace_buf import trace_pkg::*; #(
  parameter int WORD_W = 64,
  parameter int XACTS  = 3,
  parameter int DEPTH  = 256
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [WORD_W-1:0]         cfg_wdata_i,
  input  logic                      trig_i,
  input  logic                      smp_valid_i,
  input  logic [XACTS*2*WORD_W-1:0] smp_data_i,
  input  logic                      rd_i,
  output logic [WORD_W-1:0]         rd_data_o,
  output logic                      frz_irq_o
);
  localparam int WORDS  = 2 * XACTS;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int WIDX_W = $clog2(WORDS);

  st_e               state;
  logic              wr_en, frz_en, rd_load, clear, cmd_rst, cmd_rd;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  cnt, rd_left;
  logic [WIDX_W-1:0] widx;
  logic [WORD_W-1:0] st_word;
  logic              unused_cfg;

  assign cmd_rst    = cfg_we_i & cfg_wdata_i[CMD_RST];
  assign cmd_rd     = cfg_we_i & cfg_wdata_i[CMD_RD];
  assign unused_cfg = ^cfg_wdata_i[WORD_W-1:CMD_FRZ+1];

  trace_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (cfg_we_i),
    .cmd_rst_i  (cmd_rst),
    .cmd_rd_i   (cmd_rd),
    .frz_opt_i  (cfg_wdata_i[CMD_FRZ]),
    .trig_i     (trig_i),
    .smp_valid_i(smp_valid_i),
    .state_o    (state),
    .wr_en_o    (wr_en),
    .wptr_o     (wptr),
    .cnt_o      (cnt),
    .frz_en_o   (frz_en),
    .irq_o      (frz_irq_o),
    .rd_load_o  (rd_load),
    .clear_o    (clear)
  );

  trace_store #(
    .WORD_W(WORD_W), .WORDS(WORDS), .DEPTH(DEPTH), .PTR_W(PTR_W), .WIDX_W(WIDX_W)
  ) u_store (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .waddr_i(wptr),
    .wdata_i(smp_data_i),
    .raddr_i(rptr),
    .rword_i(widx),
    .rdata_o(st_word)
  );

  trace_rdout #(
    .WORD_W(WORD_W), .WORDS(WORDS), .DEPTH(DEPTH), .PTR_W(PTR_W),
    .CNT_W(CNT_W), .WIDX_W(WIDX_W)
  ) u_rdout (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .load_i (rd_load),
    .wptr_i (wptr),
    .cnt_i  (cnt),
    .rd_i   (rd_i),
    .word_i (st_word),
    .rptr_o (rptr),
    .widx_o (widx),
    .left_o (rd_left),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/trace_buf_chk.sv
module trace_buf_chk import trace_pkg::*; #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 256,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              cmd_rst_i,
  input logic              trig_i,
  input logic              rd_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              frz_irq_o,
  input st_e               state_i,
  input logic              wr_en_i,
  input logic [PTR_W-1:0]  wptr_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              frz_en_i,
  input logic [CNT_W-1:0]  left_i
);
  p_wptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> wptr_i == (($past(wptr_i) == PTR_W'(DEPTH-1)) ? '0 : $past(wptr_i) + 1'b1));

  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && frz_en_i && cnt_i >= CNT_W'(DEPTH-1) |=> frz_irq_o && state_i == ST_FROZEN);

  p_irq_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_irq_o && !cmd_rst_i |=> frz_irq_o);

  p_no_irq_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !frz_en_i |=> !frz_irq_o);

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  p_reset_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst_i |=> !frz_irq_o && cnt_i == '0 && wptr_i == '0 && state_i == ST_IDLE);

  p_trig_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE && !trig_i |=> state_i != ST_CAPT);

  p_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != ST_CAPT |-> !wr_en_i);

  p_trig_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FROZEN || state_i == ST_READ) && !cfg_we_i |=> $stable(state_i));

  p_rd_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && left_i == '0 |=> rd_data_o == '0);

  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !cmd_rst_i |=> $stable(rd_data_o));
endmodule

bind trace_buf trace_buf_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .cmd_rst_i(cmd_rst),
  .trig_i   (trig_i),
  .rd_i     (rd_i),
  .rd_data_o(rd_data_o),
  .frz_irq_o(frz_irq_o),
  .state_i  (state),
  .wr_en_i  (wr_en),
  .wptr_i   (wptr),
  .cnt_i    (cnt),
  .frz_en_i (frz_en),
  .left_i   (rd_left)
);

// File: tb/test_trace_buf.sv
module test_trace_buf;
  localparam int WORD_W = 64;
  localparam int XACTS  = 3;
  localparam int DEPTH  = 8;
  localparam int WORDS  = 2 * XACTS;
  localparam logic [63:0] C_RST = 64'h1, C_RD = 64'h2, C_FRZ = 64'h4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [WORD_W-1:0] cfg_wdata_i = '0;
  logic trig_i = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [WORDS*WORD_W-1:0] smp_data_i = '0;
  logic rd_i = 1'b0;
  logic [WORD_W-1:0] rd_data_o;
  logic frz_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];
  logic rd_pend_q;

  always #2.5ns clk_i = ~clk_i;

  trace_buf #(.WORD_W(WORD_W), .XACTS(XACTS), .DEPTH(DEPTH)) i_trace_buf (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .trig_i, .smp_valid_i,
    .smp_data_i, .rd_i, .rd_data_o, .frz_irq_o
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wd(input int s, input int w);
    return {16'hC0DE, 16'(s), 16'(w), 16'h5A5A};
  endfunction

  task automatic step();
    @(posedge clk_i);
    #1ns;
  endtask

  task automatic cfg(input logic [63:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic sample(input int s);
    smp_valid_i = 1'b1;
    for (int w = 0; w < WORDS; w++) smp_data_i[w*WORD_W +: WORD_W] = wd(s, w);
    step();
    smp_valid_i = 1'b0;
  endtask

  task automatic rd_exp(input logic [63:0] e, input string tag);
    rd_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    step();
    rd_i = 1'b0;
  endtask

  task automatic rd_bundle(input int s, input string tag);
    for (int w = WORDS - 1; w >= 0; w--) rd_exp(wd(s, w), tag);
  endtask

  task automatic trig();
    trig_i = 1'b1;
    step();
    trig_i = 1'b0;
  endtask

  // monitor: compare each read result the cycle after its strobe
  always @(posedge clk_i) rd_pend_q <= rd_i;
  always @(negedge clk_i) begin
    if (rd_pend_q === 1'b1) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard empty", rd_data_o, '0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(rd_data_o === e, t, rd_data_o, e);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    check(1'b0, "watchdog expired", '0, '0);
    report();
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    check(frz_irq_o === 1'b0, "R12 irq after reset", 64'(frz_irq_o), 0);
    check(rd_data_o === '0, "R12 read data after reset", rd_data_o, 0);

    rd_exp('0, "R9 read before start-read");

    // freeze mode; samples before and with the trigger are dropped
    cfg(C_FRZ);
    sample(90);
    sample(91);
    trig_i = 1'b1;
    sample(92);
    trig_i = 1'b0;
    for (int s = 1; s <= DEPTH - 1; s++) sample(s);
    check(frz_irq_o === 1'b0, "R4 irq low before full", 64'(frz_irq_o), 0);
    sample(DEPTH);
    check(frz_irq_o === 1'b1, "R4 irq on full", 64'(frz_irq_o), 1);
    sample(93);
    sample(94);
    trig();
    check(frz_irq_o === 1'b1, "R4 R11 irq held while frozen", 64'(frz_irq_o), 1);

    // start-read with a coincident read: that read returns zero
    cfg_we_i = 1'b1; cfg_wdata_i = C_RD | C_FRZ; rd_i = 1'b1;
    exp_q.push_back('0); tag_q.push_back("R9 read in start-read cycle");
    step();
    cfg_we_i = 1'b0; rd_i = 1'b0;
    for (int s = DEPTH; s > DEPTH - 3; s--) rd_bundle(s, "R8 R1 R2 reversed readout");
    sample(95);
    sample(96);
    trig();
    for (int s = DEPTH - 3; s >= 1; s--) rd_bundle(s, "R10 R11 readout unaffected");
    rd_exp('0, "R9 read after drain");
    check(frz_irq_o === 1'b1, "R4 irq held through readout", 64'(frz_irq_o), 1);

    // reset wins over start-read in the same write
    cfg(C_RST | C_RD);
    check(frz_irq_o === 1'b0, "R6 irq cleared by reset", 64'(frz_irq_o), 0);
    rd_exp('0, "R6 reset beats start-read");

    // wrap with freeze option clear
    trig();
    for (int s = 20; s <= 30; s++) sample(s);
    check(frz_irq_o === 1'b0, "R5 no irq on wrap", 64'(frz_irq_o), 0);
    cfg(C_RD);
    for (int s = 30; s > 30 - DEPTH; s--) rd_bundle(s, "R5 R3 wrapped readout");
    rd_exp('0, "R9 read after wrapped drain");

    // partial fill, restart of readout
    cfg(C_RST | C_FRZ);
    trig();
    sample(40);
    sample(41);
    sample(42);
    check(frz_irq_o === 1'b0, "R4 no irq when not full", 64'(frz_irq_o), 0);
    cfg(C_RD | C_FRZ);
    rd_bundle(42, "R8 partial readout");
    rd_exp(wd(41, WORDS - 1), "R8 partial readout");
    cfg(C_RD | C_FRZ);
    for (int s = 42; s >= 40; s--) rd_bundle(s, "R7 restarted readout");
    rd_exp('0, "R9 read after partial drain");

    repeat (3) step();
    check(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 0);
    report();
    $finish;
  end
endmodule